// File: doc/BRIEF.md
# Single-Cycle 8-bit Accumulator Processor Core

This core is a small Harvard-style processor. Program words are 16 bits wide and come from a separate program store. The high byte of each word is the instruction and the low byte is an 8-bit immediate operand, which is present even when the instruction does not use it. A single instruction byte selects three things: an ALU operation, an addressing/destination mode, and the source of the internal data bus. Each clock executes one instruction with no microcode. During that same clock the next program word is fetched, so the word that follows a branch always executes. That word is the branch delay slot.

State held in the core is a 16-bit program counter, the instruction and operand buffers, an 8-bit accumulator, two write-only index registers (a low index and a page index), and a write-only output register. An 8-bit input port can be placed on the bus. Data memory is external. The core drives a 15-bit address, a write strobe and write data, and reads the memory combinationally in the same cycle. Because only 15 address bits leave the core, the top half of a 64 KB data space aliases onto the bottom half. The program store is read combinationally from the address the core presents.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, `rom_addr` is 0, `out_port` is 0 and `ram_we` is 0. The first word executed after reset is the word at address 0. Reset loads the executing slot with a no-operation (instruction 0x02, which places the accumulator on the bus and reloads it into itself). Reset also clears the accumulator and all index and output registers.
- R2: Instruction bits [1:0] pick the bus value. 00 is the operand byte, 01 is `ram_rdata`, 10 is the accumulator and 11 is `in_port`.
- R3: Instruction bits [7:5] pick the operation. 000 passes the bus through. 001, 010 and 011 are AND, OR and XOR with the accumulator. 100 is accumulator plus bus, modulo 256. 101 is accumulator minus bus, modulo 256.
- R4: For ALU ops and stores, instruction bits [4:2] form the data address. The high byte is the page index for modes 010, 011 and 111, and zero otherwise. The low byte is the low index for modes 001, 011 and 111, and the operand otherwise. `ram_addr` is the low 15 bits of that 16-bit address. Branches address {0, operand}.
- R5: For ALU ops, modes 000 to 011 write the result to the accumulator. Mode 100 writes it to the low index, mode 101 to the page index, and modes 110 and 111 to `out_port`.
- R6: Mode 111 on any non-branch op increments the low index after use. The increment wraps 0xFF to 0x00 and leaves the page index unchanged.
- R7: Op 110 (store) raises `ram_we` with the bus value on `ram_wdata`, unless the bus source is 01, in which case no write occurs. A store leaves the accumulator and `out_port` alone. A store in mode 100 or 101 copies the accumulator into the low or page index.
- R8: Op 111 branches on the accumulator. Mode 001 is >0, 010 is <0, 011 is ≠0, 100 is =0, 101 is ≥0, 110 is ≤0 and 111 is always, with signed interpretation. A taken branch loads the PC with {high byte of the delay-slot address, bus}. Otherwise the PC advances by one each cycle.
- R9: Branch mode 000 is an unconditional far jump to {page index, bus}.
- R10: The word after any branch, taken or not, executes before the branch target does.
- R11: No op other than store ever raises `ram_we`, and a branch changes no data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 16 | Address of the program word being fetched |
| rom_data | input | 16 | Program word: instruction [15:8], operand [7:0] |
| in_port | input | 8 | External input byte |
| out_port | output | 8 | Output register |
| ram_addr | output | 15 | Data memory address |
| ram_we | output | 1 | Data memory write strobe |
| ram_wdata | output | 8 | Data memory write value |
| ram_rdata | input | 8 | Data memory read value, combinational from `ram_addr` |

## Verification
The properties assume two things about the surroundings. First, `rom_data` is a pure function of `rom_addr` and is stable by the sampling edge. Second, `ram_rdata` settles within the same cycle from `ram_addr`. The PC-advance and fetch-capture properties depend on both. The stimulus meets these assumptions by serving the program store and the data memory as arrays read combinationally in the bench, with memory writes taken only on the rising edge. Input-port values change only at the falling edge, so every opcode, mode and bus-source combination is reached with settled operands. A directed preamble and pseudo-random program images under several resets cover the remaining cases.

// File: rtl/acc8_pkg.sv
// Package: shared encodings and the decoded control bundle for the
// accumulator core. Assumes the instruction layout op[7:5] mode[4:2] src[1:0].
package acc8_pkg;

    typedef enum logic [2:0] {
        OP_PASS = 3'b000,
        OP_AND  = 3'b001,
        OP_OR   = 3'b010,
        OP_XOR  = 3'b011,
        OP_ADD  = 3'b100,
        OP_SUB  = 3'b101,
        OP_ST   = 3'b110,
        OP_BR   = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'b00,
        SRC_MEM = 2'b01,
        SRC_ACC = 2'b10,
        SRC_INP = 2'b11
    } src_e;

    // Reset instruction: pass the accumulator into itself.
    localparam logic [7:0] NOP_INSN = 8'h02;

    typedef struct packed {
        logic is_br;   // branch op
        logic wr_acc;  // result to accumulator
        logic wr_ix;   // result to low index
        logic wr_pg;   // result to page index
        logic wr_out;  // result to output register
        logic inc_ix;  // post-increment low index
        logic hi_pg;   // address high byte from page index
        logic lo_ix;   // address low byte from low index
        logic mem_we;  // data memory write
    } ctrl_t;

endpackage

// File: rtl/acc8_decode.sv
// Decoder: turns the executing instruction byte into register-write,
// address-select and memory-write controls. Assumes the package layout.
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [7:0] insn,
    output ctrl_t      ctl
);
    op_e        op;
    logic [2:0] mode;
    src_e       src;

    assign op   = op_e'(insn[7:5]);
    assign mode = insn[4:2];
    assign src  = src_e'(insn[1:0]);

    // Purpose: derive all per-cycle controls from op, mode and source.
    always_comb begin
        logic br, st;
        br = (op == OP_BR);
        st = (op == OP_ST);
        ctl        = '0;
        ctl.is_br  = br;
        ctl.hi_pg  = !br && (mode == 3'd2 || mode == 3'd3 || mode == 3'd7);
        ctl.lo_ix  = !br && (mode == 3'd1 || mode == 3'd3 || mode == 3'd7);
        ctl.wr_acc = !br && !st && !mode[2];
        ctl.wr_ix  = !br && (mode == 3'd4);
        ctl.wr_pg  = !br && (mode == 3'd5);
        ctl.wr_out = !br && !st && (mode[2:1] == 2'b11);
        ctl.inc_ix = !br && (mode == 3'd7);
        ctl.mem_we = st && (src != SRC_MEM);
    end
endmodule

// File: rtl/acc8_alu.sv
// ALU: combines accumulator and bus per the op field. A store passes the
// accumulator (used for the index copy); a branch yields the negated accumulator.
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] res
);
    // Purpose: select the arithmetic or logic result.
    always_comb begin
        unique case (op_e'(op))
            OP_PASS: res = bus;
            OP_AND:  res = acc & bus;
            OP_OR:   res = acc | bus;
            OP_XOR:  res = acc ^ bus;
            OP_ADD:  res = acc + bus;
            OP_SUB:  res = acc - bus;
            OP_ST:   res = acc;
            default: res = '0 - acc;
        endcase
    end
endmodule

// File: rtl/acc8_branch.sv
// Branch condition unit: evaluates the mode field as a condition on the
// signed accumulator. Mode 000 is a far jump and is always taken.
module acc8_branch #(
    parameter int DW = 8
) (
    input  logic          is_br,
    input  logic [2:0]    cond,
    input  logic [DW-1:0] acc,
    output logic          take,
    output logic          far
);
    logic zero, neg, hit;

    // Purpose: match accumulator sign/zero against the condition mask.
    always_comb begin
        zero = (acc == '0);
        neg  = acc[DW-1];
        if (zero)     hit = cond[2];
        else if (neg) hit = cond[1];
        else          hit = cond[0];
        far  = (cond == 3'b000);
        take = is_br && (far || hit);
    end
endmodule

// File: rtl/acc8_core.sv
// Top: single-cycle accumulator core. Holds PC, fetched word, accumulator,
// index, page and output registers. Assumes combinational program and data
// memory reads settle within the cycle; data writes land on the rising edge.
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DW  = 8,
    parameter int RAW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [2*DW-1:0]   rom_addr,
    input  logic [2*DW-1:0]   rom_data,
    input  logic [DW-1:0]     in_port,
    output logic [DW-1:0]     out_port,
    output logic [RAW-1:0]    ram_addr,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata
);
    localparam int PW = 2 * DW;
    localparam int HB = RAW - DW;

    logic [PW-1:0] pc_q, pc_nx;
    logic [DW-1:0] ir_q, d_q, acc_q, x_q, y_q, out_q;
    logic [DW-1:0] bus, res, hi_b, lo_b;
    ctrl_t         ctl;
    logic          take, far;

    acc8_decode u_dec (.insn(ir_q), .ctl(ctl));

    acc8_alu #(.DW(DW)) u_alu (
        .op(ir_q[7:5]), .acc(acc_q), .bus(bus), .res(res)
    );

    acc8_branch #(.DW(DW)) u_br (
        .is_br(ctl.is_br), .cond(ir_q[4:2]), .acc(acc_q),
        .take(take), .far(far)
    );

    // Purpose: form the data address from page/zero and index/operand.
    always_comb begin
        hi_b = ctl.hi_pg ? y_q : '0;
        lo_b = ctl.lo_ix ? x_q : d_q;
    end

    assign ram_addr = {hi_b[HB-1:0], lo_b};

    // Purpose: pick the bus source.
    always_comb begin
        unique case (src_e'(ir_q[1:0]))
            SRC_IMM: bus = d_q;
            SRC_MEM: bus = ram_rdata;
            SRC_ACC: bus = acc_q;
            default: bus = in_port;
        endcase
    end

    // Purpose: next fetch address (sequential, in-page or far).
    always_comb begin
        if (take) pc_nx = far ? {y_q, bus} : {pc_q[PW-1:DW], bus};
        else      pc_nx = pc_q + PW'(1);
    end

    // Purpose: fetch register stage overlapping execution.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= NOP_INSN;
            d_q  <= '0;
        end else begin
            pc_q <= pc_nx;
            ir_q <= rom_data[PW-1:DW];
            d_q  <= rom_data[DW-1:0];
        end
    end

    // Purpose: architectural register writes of the executing instruction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
            out_q <= '0;
        end else begin
            if (ctl.wr_acc) acc_q <= res;
            if (ctl.wr_pg)  y_q   <= res;
            if (ctl.wr_out) out_q <= res;
            if (ctl.wr_ix)       x_q <= res;
            else if (ctl.inc_ix) x_q <= x_q + DW'(1);
        end
    end

    assign rom_addr  = pc_q;
    assign out_port  = out_q;
    assign ram_we    = ctl.mem_we;
    assign ram_wdata = bus;
endmodule

// File: rtl/acc8_core_chk.sv
// Checker: temporal properties of the core, bound into acc8_core.
// Assumes program words are a function of rom_addr.
module acc8_core_chk #(
    parameter int DW  = 8,
    parameter int RAW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2*DW-1:0]   rom_addr,
    input logic [2*DW-1:0]   rom_data,
    input logic [RAW-1:0]    ram_addr,
    input logic              ram_we,
    input logic [DW-1:0]     ir_q,
    input logic [DW-1:0]     x_q,
    input logic [DW-1:0]     y_q
);
    // R1
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> rom_addr == '0);

    // R11
    only_store_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[7:5] != 3'b110) |-> !ram_we);

    // R7
    mem_src_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[7:5] == 3'b110 && ir_q[1:0] == 2'b01) |-> !ram_we);

    // R6
    ix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[7:5] != 3'b111 && ir_q[4:2] == 3'b111)
        |=> (x_q == DW'($past(x_q) + DW'(1))) && $stable(y_q));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[7:5] != 3'b111) |=> rom_addr == $past(rom_addr) + (2*DW)'(1));

    // R10
    slot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ir_q == $past(rom_data[2*DW-1:DW]));

    // R4
    zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[4:2] == 3'b000 || ir_q[7:5] == 3'b111) |-> ram_addr[RAW-1:DW] == '0);
endmodule

bind acc8_core acc8_core_chk #(.DW(DW), .RAW(RAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .ir_q(ir_q), .x_q(x_q), .y_q(y_q)
);

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rom_addr, rom_data;
    logic [7:0]  in_port = 8'h00;
    logic [7:0]  out_port, ram_wdata, ram_rdata;
    logic [14:0] ram_addr;
    logic        ram_we;

    logic [15:0] rom  [2048];
    logic [7:0]  bram [2048];
    logic [7:0]  mram [2048];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_pc;
    logic [7:0]  m_ir, m_d, m_ac, m_x, m_y, m_out;
    logic [31:0] seed;

    acc8_core u0 (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .in_port(in_port), .out_port(out_port), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always #2.5 clk = ~clk;

    assign rom_data  = rom[rom_addr[10:0]];
    assign ram_rdata = bram[ram_addr[10:0]];

    always @(posedge clk) if (ram_we) bram[ram_addr[10:0]] <= ram_wdata;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_image(input int phase);
        seed = 32'h1234_5679 + phase * 32'h9E37;
        for (int i = 0; i < 2048; i++) begin
            seed = nxt(seed);
            rom[i] = seed[15:0];
            bram[i] = seed[23:16];
            mram[i] = seed[23:16];
        end
        if (phase == 0) begin
            rom[0]  = 16'h10FF; // X = FF
            rom[1]  = 16'h1481; // Y = 81
            rom[2]  = 16'h1C55; // R6: out via [Y,X], X wraps to 00
            rom[3]  = 16'h0D00; // R4: AC = mem[{01,00}] (Y bit7 mirrored away)
            rom[4]  = 16'hC210; // R7: store AC to [0,10]
            rom[5]  = 16'hD220; // R7: store AC, copy AC into X
            rom[6]  = 16'hC130; // R7: store with memory source -> no write
            rom[7]  = 16'h0000; // AC = 0
            rom[8]  = 16'hF00C; // R8: branch if zero to 0x000C
            rom[9]  = 16'h1877; // R10: delay slot executes
            rom[10] = 16'h18EE; // skipped
            rom[12] = 16'h1403; // Y = 03
            rom[13] = 16'hE040; // R9: far jump to 0x0340
            rom[14] = 16'h1899; // R10: delay slot
        end
    endtask

    // Compare ports against the reference, then advance it one instruction.
    task automatic model_cycle();
        logic [2:0]  op, md;
        logic [1:0]  src;
        logic [15:0] ad;
        logic [7:0]  hi, lo, bv, r;
        logic        we, tk;
        op = m_ir[7:5]; md = m_ir[4:2]; src = m_ir[1:0];
        if (op == 3'd7) begin hi = 8'h00; lo = m_d; end
        else begin
            hi = (md == 2 || md == 3 || md == 7) ? m_y : 8'h00;
            lo = (md == 1 || md == 3 || md == 7) ? m_x : m_d;
        end
        ad = {hi, lo};
        case (src)
            2'd0: bv = m_d;
            2'd1: bv = mram[ad[10:0]];
            2'd2: bv = m_ac;
            default: bv = in_port;
        endcase
        we = (op == 3'd6) && (src != 2'd1);
        chk("R1 R8 R9 R10 rom_addr", rom_addr, m_pc);
        chk("R2 R3 R5 R6 out_port", out_port, m_out);
        chk("R4 R6 ram_addr", ram_addr, ad[14:0]);
        chk("R7 R11 ram_we", ram_we, we);
        if (we) chk("R2 R7 ram_wdata", ram_wdata, bv);
        tk = 1'b0;
        if (op == 3'd7) begin
            if (md == 0) tk = 1'b1;
            else if (m_ac == 0) tk = md[2];
            else if (m_ac[7]) tk = md[1];
            else tk = md[0];
        end
        if (op == 3'd6) begin
            if (we) mram[ad[10:0]] = bv;
            if (md == 4) m_x = m_ac;
            else if (md == 7) m_x = m_x + 1;
            if (md == 5) m_y = m_ac;
        end else if (op != 3'd7) begin
            case (op)
                3'd0: r = bv;
                3'd1: r = m_ac & bv;
                3'd2: r = m_ac | bv;
                3'd3: r = m_ac ^ bv;
                3'd4: r = m_ac + bv;
                default: r = m_ac - bv;
            endcase
            if (md < 4) m_ac = r;
            if (md == 4) m_x = r;
            if (md == 5) m_y = r;
            if (md >= 6) m_out = r;
            if (md == 7) m_x = m_x + 1;
        end
        m_ir = rom[m_pc[10:0]][15:8];
        m_d  = rom[m_pc[10:0]][7:0];
        if (tk) m_pc = (md == 0) ? {m_y, bv} : {m_pc[15:8], bv};
        else    m_pc = m_pc + 1;
    endtask

    initial begin
        logic [31:0] ins;
        ins = 32'hACE1_0001;
        for (int ph = 0; ph < 4; ph++) begin
            rst_n = 1'b0;
            load_image(ph);
            m_pc = 0; m_ir = 8'h02; m_d = 0;
            m_ac = 0; m_x = 0; m_y = 0; m_out = 0;
            repeat (3) @(negedge clk);
            // R1: reset state at the ports
            chk("R1 reset rom_addr", rom_addr, 0);
            chk("R1 reset out_port", out_port, 0);
            chk("R1 reset ram_we", ram_we, 0);
            rst_n = 1'b1;
            for (int c = 0; c < 1500; c++) begin
                if (c != 0) @(negedge clk);
                ins = nxt(ins);
                in_port = ins[7:0];
                #1;
                model_cycle();
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule